// File: doc/BRIEF.md
# Paired External Interrupt Controller

The block collects eight interrupt request lines, arranged as four pairs named A, B, C and D. Each pair has an even channel and an odd channel. Each channel is an edge-triggered source with its own edge polarity, a latched pending flag and an enable bit. Every channel except A0 can take its request from either an external pin or an internal peripheral request line. A per-channel select input chooses between them. Pins pass through a two-flop synchroniser before edge detection. Peripheral request lines are taken as already synchronous to the clock.

Priority is set per pair, not per channel. Each pair's two-bit priority value forms the upper bits of a 3-bit level. The even channel gets that value with LSB 0 and the odd channel gets it with LSB 1, so the odd channel always ranks just below its even partner. The block presents the winning unmasked pending channel with its level and vector index. An acknowledge pulse from the CPU clears that channel's pending flag. Software reaches the four control registers through a simple write port and a combinational read port.

Top module: `pxi_ctrl`

## Requirements
- R1: After reset the trigger, pending, enable and priority registers all read 0 and irq_o is low.
- R2: A trigger bit of 1 sets the channel's pending flag on a rising edge of its selected source. A trigger bit of 0 sets it on a falling edge. The opposite edge has no effect.
- R3: A pin change shows in the pending register after the third rising clock edge that follows the change. A peripheral line change shows after the first rising clock edge that follows it.
- R4: Register addresses are 0 for trigger, 1 for pending, 2 for enable and 3 for priority. In the trigger, pending and enable registers, bit i belongs to channel i, with A0=0, A1=1, B0=2, B1=3, C0=4, C1=5, D0=6 and D1=7.
- R5: An enable bit of 1 unmasks its channel. A pending channel whose enable bit is 0 stays pending, but it does not raise irq_o and it is not presented.
- R6: Priority register bits [2p+1:2p] belong to pair p, with A=0, B=1, C=2 and D=3. A channel's level is {pair bits, channel is odd}. The lowest level wins, and between equal levels the lower channel index wins.
- R7: When ack_i is high for one cycle while irq_o is high, the presented channel's pending flag clears at that clock edge, and the next candidate is then presented.
- R8: Writing the pending register clears each bit written as 0 and leaves each bit written as 1 unchanged. An edge on a channel in the same cycle as a clearing write leaves that channel pending.
- R9: When src_sel_i[i] is 1, channels 1 to 7 use periph_i[i], and when it is 0 they use pin_i[i]. Channel 0 always uses pin_i[0], whatever src_sel_i[0] is.
- R10: Changing a channel's source select never causes an edge on that channel, even when the old and new sources are at different levels.
- R11: irq_o is high exactly when some channel is both pending and enabled. irq_vec_o then gives the winning channel index and irq_level_o gives its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | External pin requests, asynchronous |
| periph_i | input | 8 | Peripheral request lines, synchronous |
| src_sel_i | input | 8 | Per-channel source select, 1 selects the peripheral |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| ack_i | input | 1 | Acknowledge pulse for the presented channel |
| irq_o | output | 1 | Interrupt request |
| irq_vec_o | output | 3 | Index of the presented channel |
| irq_level_o | output | 3 | Level of the presented channel |

## Verification
Results come due at different points, so each check waits the exact number of clock edges for its path. A pin event is checked one edge early and must not yet be pending, then checked on the third edge, where it must be pending. A peripheral event, a register write and an acknowledge each take effect on the first edge after the input is driven. The presented vector and level follow the pending register combinationally, so they are checked in that same cycle. Inputs change on the falling clock edge and results are sampled just after it. This puts every sample half a period away from the edge that updates the registers.

// File: rtl/pxi_pkg.sv
package pxi_pkg;
  localparam int unsigned NUM_PAIRS  = 4;
  localparam int unsigned NUM_CH     = 2 * NUM_PAIRS;
  localparam int unsigned CH_W       = $clog2(NUM_CH);
  localparam int unsigned PAIR_LVL_W = 2;
  localparam int unsigned LVL_W      = PAIR_LVL_W + 1;
  localparam int unsigned PRIO_W     = PAIR_LVL_W * NUM_PAIRS;
  localparam int unsigned REG_W      = NUM_CH;

  typedef enum logic [1:0] {
    REG_TRIG = 2'd0,
    REG_PEND = 2'd1,
    REG_MASK = 2'd2,
    REG_PRIO = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pxi_edge_det.sv
module pxi_edge_det #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          HAS_PERIPH  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic periph_i,
  input  logic src_sel_i,
  input  logic rise_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic sel, sel_q, cur, prev_q, switched;

  // idle high: reset trigger polarity is falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign sel = src_sel_i & HAS_PERIPH;
  assign cur = sel ? periph_i : sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      sel_q  <= sel;
      prev_q <= cur;
    end
  end

  // a source switch reloads the history without reporting an edge
  assign switched = sel ^ sel_q;
  assign edge_o   = ~switched & (rise_i ? (cur & ~prev_q) : (~cur & prev_q));
endmodule

// File: rtl/pxi_arbiter.sv
module pxi_arbiter
  import pxi_pkg::*;
(
  input  logic [NUM_CH-1:0] req_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [LVL_W-1:0] lvl_w [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lvl
    assign lvl_w[g] = {prio_i[PAIR_LVL_W*(g/2) +: PAIR_LVL_W], 1'(g % 2)};
  end

  // strict compare keeps the lower index on ties
  always_comb begin
    valid_o = 1'b0;
    ch_o    = '0;
    level_o = '1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req_i[i] && (!valid_o || lvl_w[i] < level_o)) begin
        valid_o = 1'b1;
        ch_o    = CH_W'(i);
        level_o = lvl_w[i];
      end
    end
  end

  always_comb begin
    if (valid_o) begin
      p_winner_live_r11: assert (req_i[ch_o]);
      p_odd_level_r6: assert (level_o[0] == ch_o[0]);
      for (int i = 0; i < NUM_CH; i++) begin
        if (req_i[i]) begin
          p_rank_r6: assert (lvl_w[i] > level_o || (lvl_w[i] == level_o && CH_W'(i) >= ch_o));
        end
      end
    end
  end
endmodule

// File: rtl/pxi_ctrl.sv
module pxi_ctrl
  import pxi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic [NUM_CH-1:0] periph_i,
  input  logic [NUM_CH-1:0] src_sel_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [CH_W-1:0]   irq_vec_o,
  output logic [LVL_W-1:0]  irq_level_o
);
  logic [NUM_CH-1:0] trig_q, pend_q, mask_q, pend_d, edge_w, pend_keep, ack_clr;
  logic [PRIO_W-1:0] prio_q;
  reg_sel_e          wr_sel;

  assign wr_sel = reg_sel_e'(wr_addr_i);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pxi_edge_det #(
      .SYNC_STAGES (SYNC_STAGES),
      .HAS_PERIPH  (g != 0)
    ) u_edge (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (pin_i[g]),
      .periph_i  (periph_i[g]),
      .src_sel_i (src_sel_i[g]),
      .rise_i    (trig_q[g]),
      .edge_o    (edge_w[g])
    );
  end

  pxi_arbiter u_arb (
    .req_i   (pend_q & mask_q),
    .prio_i  (prio_q),
    .valid_o (irq_o),
    .ch_o    (irq_vec_o),
    .level_o (irq_level_o)
  );

  assign pend_keep = (wr_en_i && wr_sel == REG_PEND) ? wr_data_i : '1;

  always_comb begin
    ack_clr = '0;
    if (ack_i && irq_o) ack_clr[irq_vec_o] = 1'b1;
  end

  // new edges are applied last so a coincident clear cannot drop them
  assign pend_d = (pend_q & pend_keep & ~ack_clr) | edge_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
      pend_q <= '0;
      mask_q <= '0;
      prio_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_en_i) begin
        unique case (wr_sel)
          REG_TRIG: trig_q <= wr_data_i;
          REG_MASK: mask_q <= wr_data_i;
          REG_PRIO: prio_q <= wr_data_i;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (reg_sel_e'(rd_addr_i))
      REG_TRIG: rd_data_o = trig_q;
      REG_PEND: rd_data_o = pend_q;
      REG_MASK: rd_data_o = mask_q;
      default:  rd_data_o = prio_q;
    endcase
  end

  p_edge_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_w) |=> ((pend_q & $past(edge_w)) == $past(edge_w)));

  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~$past(pend_q) & ~$past(edge_w)) == '0);

  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !edge_w[irq_vec_o]) |=> !pend_q[$past(irq_vec_o)]);
endmodule

// File: tb/pxi_ctrl_tb.sv
module pxi_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = 8'hFF, periph = 8'hFF, src_sel = 8'h00;
  logic       wr_en = 1'b0, ack = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;
  logic [2:0] vec, lvl;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pxi_ctrl u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pin),
    .periph_i    (periph),
    .src_sel_i   (src_sel),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .ack_i       (ack),
    .irq_o       (irq),
    .irq_vec_o   (vec),
    .irq_level_o (lvl)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic check_pend(input string req, input logic [7:0] exp);
    logic [7:0] d;
    reg_read(2'd1, d);
    check(req, "pending", d, exp);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), d);
      check("R1", "reset reg", d, 8'h00);
    end
    check("R1", "reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_falling_pin();
    reg_write(2'd2, 8'hFF);
    pin[1] = 1'b0;
    tick(2);
    check_pend("R3", 8'h00);
    tick(1);
    check_pend("R3", 8'h02);
    check("R11", "irq", {7'd0, irq}, 8'h01);
    check("R4", "vec", {5'd0, vec}, 8'd1);
    check("R6", "level", {5'd0, lvl}, 8'd1);
    pin[1] = 1'b1;
    tick(3);
    check_pend("R2", 8'h02);
    reg_write(2'd1, 8'h00);
    check_pend("R8", 8'h00);
  endtask

  task automatic t_rising_pin();
    reg_write(2'd0, 8'h04);
    pin[2] = 1'b0;
    tick(3);
    check_pend("R2", 8'h00);
    pin[2] = 1'b1;
    tick(3);
    check_pend("R2", 8'h04);
    reg_write(2'd0, 8'h00);
    reg_write(2'd1, 8'h00);
  endtask

  task automatic t_mask();
    reg_write(2'd2, 8'hF7);
    pin[3] = 1'b0;
    tick(3);
    check_pend("R5", 8'h08);
    check("R5", "masked irq", {7'd0, irq}, 8'h00);
    reg_write(2'd2, 8'hFF);
    check("R5", "unmasked irq", {7'd0, irq}, 8'h01);
    check("R5", "unmasked vec", {5'd0, vec}, 8'd3);
    pin[3] = 1'b1;
    tick(3);
    reg_write(2'd1, 8'h00);
  endtask

  task automatic t_priority();
    pin[0] = 1'b0; pin[5] = 1'b0;
    tick(3);
    check_pend("R4", 8'h21);
    reg_write(2'd3, 8'hC9);
    check("R6", "vec C1", {5'd0, vec}, 8'd5);
    check("R6", "level C1", {5'd0, lvl}, 8'd1);
    do_ack();
    check_pend("R7", 8'h01);
    check("R7", "next vec", {5'd0, vec}, 8'd0);
    check("R6", "level A0", {5'd0, lvl}, 8'd2);
    do_ack();
    check_pend("R7", 8'h00);
    check("R11", "irq idle", {7'd0, irq}, 8'h00);
    pin[0] = 1'b1; pin[5] = 1'b1;
    tick(3);
  endtask

  task automatic t_tie();
    reg_write(2'd3, 8'h05);
    pin[0] = 1'b0; pin[2] = 1'b0; pin[7] = 1'b0;
    tick(3);
    check("R6", "vec D1", {5'd0, vec}, 8'd7);
    check("R6", "level D1", {5'd0, lvl}, 8'd1);
    do_ack();
    check("R6", "tie vec", {5'd0, vec}, 8'd0);
    check("R6", "tie level", {5'd0, lvl}, 8'd2);
    do_ack();
    check("R7", "last vec", {5'd0, vec}, 8'd2);
    pin[0] = 1'b1; pin[2] = 1'b1; pin[7] = 1'b1;
    tick(3);
    reg_write(2'd1, 8'h00);
    reg_write(2'd3, 8'h00);
  endtask

  task automatic t_source();
    src_sel[0] = 1'b1;
    tick(1);
    periph[0] = 1'b0;
    tick(3);
    check_pend("R9", 8'h00);
    periph[0] = 1'b1;
    src_sel[0] = 1'b0;
    periph[3] = 1'b0;
    tick(1);
    src_sel[3] = 1'b1;
    tick(1);
    check_pend("R10", 8'h00);
    tick(2);
    check_pend("R10", 8'h00);
    periph[3] = 1'b1;
    tick(1);
    check_pend("R2", 8'h00);
    periph[3] = 1'b0;
    tick(1);
    check_pend("R9", 8'h08);
    periph[3] = 1'b1;
    src_sel[3] = 1'b0;
    tick(1);
    reg_write(2'd1, 8'h00);
  endtask

  task automatic t_sw_clear();
    src_sel[6] = 1'b1;
    tick(1);
    periph[6] = 1'b0;
    tick(1);
    check_pend("R3", 8'h40);
    reg_write(2'd1, 8'hFF);
    check_pend("R8", 8'h40);
    reg_write(2'd1, 8'h00);
    check_pend("R8", 8'h00);
    periph[6] = 1'b1;
    tick(1);
    periph[6] = 1'b0;
    reg_write(2'd1, 8'h00);
    check_pend("R8", 8'h40);
    periph[6] = 1'b1;
    src_sel[6] = 1'b0;
    tick(1);
    reg_write(2'd1, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_falling_pin();
    t_rising_pin();
    t_mask();
    t_priority();
    t_tie();
    t_source();
    t_sw_clear();
    tick(2);
    finish_run();
  end
endmodule